// File: doc/BRIEF.md
# Coprocessor Power-Domain Sequencer

This block moves a switchable SIMD coprocessor domain between a powered, running state and an unpowered, isolated state. It owns four control lines: an active-low reset for the main core, a separate active-low reset for the coprocessor, an enable for the coprocessor's output clamps, and an enable for the domain's power switch. Software asks for a change with a one-cycle `down_req` or `up_req`. The block reports progress on `seq_busy` and `dom_off`. It also raises `cp_unavail` whenever the coprocessor cannot execute, so that the instruction decoder can trap coprocessor instructions as undefined.

Power-down runs through the states ON → HOLD → CLAMP → CUT → OFF. ON → HOLD is taken on `down_req`. HOLD asserts both resets and keeps them low for MIN_HOLD cycles. HOLD → CLAMP happens when the hold count expires. CLAMP → CUT and CUT → OFF each take one cycle. In CUT the power switch opens. Entering OFF releases the core reset, while the coprocessor reset stays low.

Power-up runs OFF → RESTORE → RELEASE → ON. OFF → RESTORE is taken on `up_req`. RESTORE closes the power switch and waits SETTLE_CYC cycles. RELEASE drops the clamp. ON then releases the coprocessor reset. The core reset is not touched during power-up.

An asynchronous system reset places the block in HOLD, so every start-up runs the full power-down order and ends in OFF. The coprocessor's output word and idle flag pass through the block. While the clamp is on, they are replaced by a fixed idle word and a forced idle indication.

Top module: `cpd_power_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are as follows: `core_rst_n`=0, `cp_rst_n`=0, `clamp_en`=0, `pwr_en`=1, `cp_unavail`=1, `seq_busy`=1 and `dom_off`=0.
- R2: After `rst_n` is released, `clamp_en` rises after the MIN_HOLD-th rising clock edge. `pwr_en` falls one edge later, and `core_rst_n` rises one edge after that, with `dom_off`=1.
- R3: A `down_req` sampled in ON drives both resets low together after that edge. They stay low for MIN_HOLD cycles before `clamp_en` rises.
- R4: `pwr_en` is low only while `clamp_en` is high. It falls exactly one cycle after `clamp_en` rises.
- R5: `core_rst_n` rises one cycle after `pwr_en` falls, while `cp_rst_n` stays low. In the resulting OFF state, `dom_off`=1 and `seq_busy`=0.
- R6: While `clamp_en`=1, `cp_data_o` equals IDLE_WORD (default all zeros) and `cp_idle_o`=1. Otherwise both pass `cp_data_i` and `cp_idle_i` through unchanged.
- R7: `cp_unavail` is high in every state except ON. In particular, it is high whenever power is off, the clamp is on, or the coprocessor reset is asserted.
- R8: An `up_req` sampled in OFF sets `pwr_en`=1 after that edge. `clamp_en` falls after SETTLE_CYC more edges, and `cp_rst_n` rises one edge later. `core_rst_n` stays 1 throughout.
- R9: `seq_busy` is high from the edge that accepts a request until ON or OFF is reached. Requests sampled while busy are ignored, as are `up_req` in ON and `down_req` in OFF.
- R10: If `down_req` and `up_req` are both high in ON, the power-down sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset; starts the power-down order |
| down_req | input | 1 | Request to power the coprocessor domain down |
| up_req | input | 1 | Request to power the coprocessor domain up |
| cp_data_i | input | DW | Raw coprocessor output word |
| cp_idle_i | input | 1 | Raw coprocessor idle indication |
| core_rst_n | output | 1 | Registered active-low main core reset |
| cp_rst_n | output | 1 | Registered active-low coprocessor reset |
| clamp_en | output | 1 | Registered coprocessor output clamp enable |
| pwr_en | output | 1 | Registered coprocessor power switch enable |
| cp_unavail | output | 1 | High when coprocessor instructions must trap |
| seq_busy | output | 1 | High while a sequence is in progress |
| dom_off | output | 1 | High when the domain is stably off |
| cp_data_o | output | DW | Coprocessor output word after clamping |
| cp_idle_o | output | 1 | Coprocessor idle flag after clamping |

## Verification
The main function is driven through a per-cycle vector table that starts from the reset-launched power-down, and the outputs are checked after every edge. The table contains a full power-up followed by a request-driven power-down. Against this background it injects three kinds of request: requests of the wrong direction in stable states, requests of either direction while a sequence is running, and both requests at once in ON. This separates a sequencer that only counts correctly from one that also ignores requests it should not act on. Directed tests then check the pass-through of the data and idle lines when unclamped, and an asynchronous reset taken from ON.

// File: rtl/cpd_pkg.sv
`timescale 1ns/1ps
package cpd_pkg;

    typedef enum logic [2:0] {
        S_ON      = 3'd0,
        S_HOLD    = 3'd1,
        S_CLAMP   = 3'd2,
        S_CUT     = 3'd3,
        S_OFF     = 3'd4,
        S_RESTORE = 3'd5,
        S_RELEASE = 3'd6
    } seq_state_t;

    typedef struct packed {
        logic core_rst_n;
        logic cp_rst_n;
        logic clamp;
        logic pwr;
    } dom_ctl_t;

    // Control levels that each state presents on the domain lines.
    function automatic dom_ctl_t ctl_of(seq_state_t s);
        dom_ctl_t c;
        unique case (s)
            S_ON:      c = '{core_rst_n: 1'b1, cp_rst_n: 1'b1, clamp: 1'b0, pwr: 1'b1};
            S_HOLD:    c = '{core_rst_n: 1'b0, cp_rst_n: 1'b0, clamp: 1'b0, pwr: 1'b1};
            S_CLAMP:   c = '{core_rst_n: 1'b0, cp_rst_n: 1'b0, clamp: 1'b1, pwr: 1'b1};
            S_CUT:     c = '{core_rst_n: 1'b0, cp_rst_n: 1'b0, clamp: 1'b1, pwr: 1'b0};
            S_OFF:     c = '{core_rst_n: 1'b1, cp_rst_n: 1'b0, clamp: 1'b1, pwr: 1'b0};
            S_RESTORE: c = '{core_rst_n: 1'b1, cp_rst_n: 1'b0, clamp: 1'b1, pwr: 1'b1};
            S_RELEASE: c = '{core_rst_n: 1'b1, cp_rst_n: 1'b0, clamp: 1'b0, pwr: 1'b1};
            default:   c = '{core_rst_n: 1'b0, cp_rst_n: 1'b0, clamp: 1'b0, pwr: 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cpd_wait_cnt.sv
`timescale 1ns/1ps
module cpd_wait_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    // Saturating up-counter, cleared on every state change.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr) begin
            cnt_o <= '0;
        end else if (cnt_o != CNT_TOP) begin
            cnt_o <= cnt_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/cpd_out_clamp.sv
`timescale 1ns/1ps
module cpd_out_clamp #(
    parameter int          DW        = 8,
    parameter logic [DW-1:0] IDLE_WORD = '0
) (
    input  logic          clamp,
    input  logic [DW-1:0] data_i,
    input  logic          idle_i,
    output logic [DW-1:0] data_o,
    output logic          idle_o
);

    // One isolation cell per bit, each forcing its own idle level.
    for (genvar g = 0; g < DW; g++) begin : g_iso
        assign data_o[g] = clamp ? IDLE_WORD[g] : data_i[g];
    end

    assign idle_o = clamp | idle_i;

endmodule

// File: rtl/cpd_seq_fsm.sv
`timescale 1ns/1ps
module cpd_seq_fsm
    import cpd_pkg::*;
#(
    parameter int MIN_HOLD   = 8,
    parameter int SETTLE_CYC = 4,
    parameter int CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             down_req,
    input  logic             up_req,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             cnt_clr,
    output logic             core_rst_n,
    output logic             cp_rst_n,
    output logic             clamp_en,
    output logic             pwr_en,
    output logic             cp_unavail,
    output logic             seq_busy,
    output logic             dom_off
);

    localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(MIN_HOLD - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam dom_ctl_t         RST_CTL     = ctl_of(S_HOLD);

    seq_state_t state_q, state_d;
    dom_ctl_t   ctl_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_ON:      if (down_req)                state_d = S_HOLD;
            S_HOLD:    if (cnt_i == HOLD_LAST)      state_d = S_CLAMP;
            S_CLAMP:                                state_d = S_CUT;
            S_CUT:                                  state_d = S_OFF;
            S_OFF:     if (up_req)                  state_d = S_RESTORE;
            S_RESTORE: if (cnt_i == SETTLE_LAST)    state_d = S_RELEASE;
            S_RELEASE:                              state_d = S_ON;
            default:                                state_d = S_HOLD;
        endcase
    end

    assign cnt_clr = (state_d != state_q);
    assign ctl_d   = ctl_of(state_d);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_HOLD;
        else        state_q <= state_d;
    end

    // Registered outputs, decoded from the next state so they track state_q.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_rst_n <= RST_CTL.core_rst_n;
            cp_rst_n   <= RST_CTL.cp_rst_n;
            clamp_en   <= RST_CTL.clamp;
            pwr_en     <= RST_CTL.pwr;
            cp_unavail <= 1'b1;
            seq_busy   <= 1'b1;
            dom_off    <= 1'b0;
        end else begin
            core_rst_n <= ctl_d.core_rst_n;
            cp_rst_n   <= ctl_d.cp_rst_n;
            clamp_en   <= ctl_d.clamp;
            pwr_en     <= ctl_d.pwr;
            cp_unavail <= (state_d != S_ON);
            seq_busy   <= (state_d != S_ON) && (state_d != S_OFF);
            dom_off    <= (state_d == S_OFF);
        end
    end

    // Run length of cycles with both resets low, used to check the hold time.
    logic [CNT_W:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!core_rst_n && !cp_rst_n) begin
            if (low_run != (CNT_W+1)'(MIN_HOLD)) low_run <= low_run + (CNT_W+1)'(1);
        end else begin
            low_run <= '0;
        end
    end

    AST_HOLD_BEFORE_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_en) |-> (low_run == (CNT_W+1)'(MIN_HOLD))); // R3

    AST_PWR_ONLY_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> clamp_en); // R4

    AST_CUT_AFTER_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> $past(clamp_en) && !core_rst_n); // R4

    AST_CORE_RELEASE_KEEPS_CP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> !cp_rst_n && !pwr_en && $past(!pwr_en)); // R5

    AST_UNAVAIL_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en || clamp_en || !cp_rst_n) |-> cp_unavail); // R7

    AST_UNCLAMP_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clamp_en) |-> pwr_en && !cp_rst_n && core_rst_n); // R8

    AST_CP_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cp_rst_n) |-> !clamp_en && !$past(clamp_en) && core_rst_n); // R8

    AST_BUSY_NOT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> !dom_off && cp_unavail); // R9

endmodule

// File: rtl/cpd_power_seq.sv
`timescale 1ns/1ps
module cpd_power_seq #(
    parameter int            MIN_HOLD   = 8,
    parameter int            SETTLE_CYC = 4,
    parameter int            DW         = 8,
    parameter logic [DW-1:0] IDLE_WORD  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          down_req,
    input  logic          up_req,
    input  logic [DW-1:0] cp_data_i,
    input  logic          cp_idle_i,
    output logic          core_rst_n,
    output logic          cp_rst_n,
    output logic          clamp_en,
    output logic          pwr_en,
    output logic          cp_unavail,
    output logic          seq_busy,
    output logic          dom_off,
    output logic [DW-1:0] cp_data_o,
    output logic          cp_idle_o
);

    localparam int CNT_MAX = (MIN_HOLD > SETTLE_CYC) ? MIN_HOLD : SETTLE_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] wait_cnt;
    logic             wait_clr;

    cpd_wait_cnt #(.CNT_W(CNT_W)) i_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wait_clr),
        .cnt_o (wait_cnt)
    );

    cpd_seq_fsm #(
        .MIN_HOLD   (MIN_HOLD),
        .SETTLE_CYC (SETTLE_CYC),
        .CNT_W      (CNT_W)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .down_req   (down_req),
        .up_req     (up_req),
        .cnt_i      (wait_cnt),
        .cnt_clr    (wait_clr),
        .core_rst_n (core_rst_n),
        .cp_rst_n   (cp_rst_n),
        .clamp_en   (clamp_en),
        .pwr_en     (pwr_en),
        .cp_unavail (cp_unavail),
        .seq_busy   (seq_busy),
        .dom_off    (dom_off)
    );

    cpd_out_clamp #(.DW(DW), .IDLE_WORD(IDLE_WORD)) i_iso (
        .clamp  (clamp_en),
        .data_i (cp_data_i),
        .idle_i (cp_idle_i),
        .data_o (cp_data_o),
        .idle_o (cp_idle_o)
    );

    AST_CLAMPED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_en |-> cp_idle_o && (cp_data_o == IDLE_WORD)); // R6

endmodule

// File: tb/test_cpd_power_seq.sv
`timescale 1ns/1ps
module test_cpd_power_seq;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          down_req, up_req;
    logic [DW-1:0] cp_data_i;
    logic          cp_idle_i;
    logic          core_rst_n, cp_rst_n, clamp_en, pwr_en;
    logic          cp_unavail, seq_busy, dom_off;
    logic [DW-1:0] cp_data_o;
    logic          cp_idle_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cpd_power_seq #(.MIN_HOLD(8), .SETTLE_CYC(4), .DW(DW), .IDLE_WORD('0)) i_cpd_power_seq (
        .clk (clk), .rst_n (rst_n), .down_req (down_req), .up_req (up_req),
        .cp_data_i (cp_data_i), .cp_idle_i (cp_idle_i),
        .core_rst_n (core_rst_n), .cp_rst_n (cp_rst_n), .clamp_en (clamp_en),
        .pwr_en (pwr_en), .cp_unavail (cp_unavail), .seq_busy (seq_busy),
        .dom_off (dom_off), .cp_data_o (cp_data_o), .cp_idle_o (cp_idle_o)
    );

    // Bits: {down, up, core_rst_n, cp_rst_n, clamp, pwr, unavail, busy, off}
    // Starts right after reset release; MIN_HOLD=8, SETTLE_CYC=4.
    localparam logic [8:0] VEC [29] = '{
        9'b000001110, 9'b000001110, 9'b000001110, 9'b000001110,   // R2 hold
        9'b000001110, 9'b000001110, 9'b000001110,
        9'b000011110,                                             // R2 clamp
        9'b000010110,                                             // R2 cut
        9'b001010101,                                             // R2 off
        9'b101010101,                                             // R9 down in OFF ignored
        9'b011011110,                                             // R8 restore
        9'b101011110, 9'b001011110, 9'b011011110,                 // R9 ignored while busy
        9'b001001110,                                             // R8 release
        9'b001101000,                                             // R8 on
        9'b011101000,                                             // R9 up in ON ignored
        9'b110001110,                                             // R10 both -> hold
        9'b000001110, 9'b010001110, 9'b100001110, 9'b000001110,   // R3 hold
        9'b000001110, 9'b000001110, 9'b000001110,
        9'b000011110,                                             // R3 clamp
        9'b000010110,                                             // R4 cut
        9'b001010101                                              // R5 off
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #1600000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; down_req = 1'b0; up_req = 1'b0;
        cp_data_i = 8'h00; cp_idle_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 core_rst_n", 32'(core_rst_n), 32'd0);
        chk("R1 cp_rst_n",   32'(cp_rst_n),   32'd0);
        chk("R1 clamp_en",   32'(clamp_en),   32'd0);
        chk("R1 pwr_en",     32'(pwr_en),     32'd1);
        chk("R1 cp_unavail", 32'(cp_unavail), 32'd1);
        chk("R1 seq_busy",   32'(seq_busy),   32'd1);
        chk("R1 dom_off",    32'(dom_off),    32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 29; i++) begin
            down_req  = VEC[i][8];
            up_req    = VEC[i][7];
            cp_data_i = 8'hA5 ^ 8'(i);
            @(negedge clk);
            chk($sformatf("R3 core_rst_n v%0d", i), 32'(core_rst_n), 32'(VEC[i][6]));
            chk($sformatf("R3 cp_rst_n v%0d", i),   32'(cp_rst_n),   32'(VEC[i][5]));
            chk($sformatf("R4 clamp_en v%0d", i),   32'(clamp_en),   32'(VEC[i][4]));
            chk($sformatf("R8 pwr_en v%0d", i),     32'(pwr_en),     32'(VEC[i][3]));
            chk($sformatf("R7 cp_unavail v%0d", i), 32'(cp_unavail), 32'(VEC[i][2]));
            chk($sformatf("R9 seq_busy v%0d", i),   32'(seq_busy),   32'(VEC[i][1]));
            chk($sformatf("R5 dom_off v%0d", i),    32'(dom_off),    32'(VEC[i][0]));
            chk($sformatf("R6 cp_data_o v%0d", i),  32'(cp_data_o),
                VEC[i][4] ? 32'd0 : 32'(8'hA5 ^ 8'(i)));
            chk($sformatf("R6 cp_idle_o v%0d", i),  32'(cp_idle_o),  32'(VEC[i][4]));
        end
        down_req = 1'b0; up_req = 1'b0;

        // R8 power up again, then R6 pass-through while unclamped
        up_req = 1'b1;
        @(negedge clk);
        up_req = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 back in ON cp_rst_n", 32'(cp_rst_n), 32'd1);
        cp_data_i = 8'h3C; cp_idle_i = 1'b0;
        #1;
        chk("R6 data pass-through", 32'(cp_data_o), 32'h3C);
        chk("R6 idle pass-through low", 32'(cp_idle_o), 32'd0);
        cp_idle_i = 1'b1;
        #1;
        chk("R6 idle pass-through high", 32'(cp_idle_o), 32'd1);

        // R1 asynchronous reset taken from ON, checked before any edge
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 async core_rst_n", 32'(core_rst_n), 32'd0);
        chk("R1 async cp_rst_n",   32'(cp_rst_n),   32'd0);
        chk("R1 async pwr_en",     32'(pwr_en),     32'd1);
        chk("R1 async cp_unavail", 32'(cp_unavail), 32'd1);
        chk("R1 async seq_busy",   32'(seq_busy),   32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (7) @(negedge clk);
        chk("R2 clamp still low after 7 edges", 32'(clamp_en), 32'd0);
        @(negedge clk);
        chk("R2 clamp after 8 edges", 32'(clamp_en), 32'd1);

        finished = 1'b1;
        summary();
    end

endmodule